// File: doc/BRIEF.md
# Nested prioritized interrupt controller

This block arbitrates among a set of level-sensitive interrupt lines and drives the entry and exit sequence of a processor model. Each line has an enable bit and a small priority field. Software writes both through a one-cycle configuration write. A lower priority value means greater urgency. When two requests have the same value, the lower line number wins. The block keeps a pending bit and an active bit per line. It also keeps a stack of running handlers, one entry per nesting level. The execution priority is the most urgent priority among the active lines. When no line is active it is the thread level, which is one step below the least urgent priority value.

When a request is more urgent than the execution priority, the block raises an entry request. Once the processor acknowledges, the block runs a fixed sequence: a stacking window of one cycle per saved register, then one vector-fetch cycle, then the handler. During the stacking window and the fetch cycle it shows the vector number and the vector-table address of the chosen line. A more urgent request that arrives before the handler starts replaces the target, and the stacking count is not restarted. On an exception return the block does one of two things. If a waiting request beats what remains after the finished handler, it chains straight into that request's vector fetch. Otherwise it runs an unstacking window and resumes the outer handler or thread mode.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset:
  - the phase is idle (code 0);
  - the nesting depth is 0;
  - no entry request is raised;
  - the vector number and the vector address are both 0.
- R2: A configuration write with `cfg_we_i` high stores `cfg_data_i[PRIO_W]` as the enable bit and `cfg_data_i[PRIO_W-1:0]` as the priority of line `cfg_idx_i`. A line whose enable bit is 0 never causes an entry request.
- R3: Among eligible requests, the lowest priority value wins, and among equal values the lowest line number wins. While stacking and fetching, the vector number is VEC_OFS plus the line number, and the vector address is VEC_BASE plus four times the vector number.
- R4: An entry request is raised only for a pending, enabled, inactive line whose priority value is strictly below the current execution priority. A request of equal or lower urgency stays pending.
- R5: The phase codes are idle 0, stacking 1, fetch 2, handler 3 and unstacking 4. The sequence runs as follows:
  - `entry_ack_i` while an entry request is raised starts stacking for STACK_WORDS cycles;
  - one fetch cycle follows;
  - then the handler phase begins and the depth rises by one.
- R6: During stacking or fetch, a request strictly more urgent than the current target replaces the target. The stacking count continues without a restart, and a replacement in the fetch cycle repeats the fetch cycle. The displaced line stays pending and is served later.
- R7: On `exc_ret_i` in the handler phase with no request eligible to chain, the block unstacks for STACK_WORDS cycles. It then returns to the handler phase of the outer handler, or to idle when the depth has reached 0.
- R8: On `exc_ret_i` in the handler phase, a pending request may be strictly more urgent than the execution priority left after the finished handler is removed. In that case the next cycle is a fetch cycle for that request, with no unstacking and no stacking, and the depth is unchanged once its handler starts.
- R9: Nesting is tracked up to 2**PRIO_W levels and shown on `depth_o`. At the maximum depth no entry request is raised, even when priorities have been changed at run time.
- R10: `exc_ret_i` outside the handler phase is ignored.
- R11: A line that is high while enabled becomes pending. It stays pending after the line falls, until it is accepted at the end of a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Level-sensitive interrupt lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | $clog2(NUM_IRQ) | Line selected by the write |
| cfg_data_i | input | PRIO_W+1 | Enable bit on top, priority below |
| entry_req_o | output | 1 | Entry (preemption) request to the processor |
| entry_ack_i | input | 1 | Processor accepts the entry request |
| exc_ret_i | input | 1 | Exception-return strobe from the running handler |
| phase_o | output | 3 | Sequence phase code |
| vec_num_o | output | $clog2(VEC_OFS+NUM_IRQ) | Vector number of target or running handler |
| vec_addr_o | output | 32 | Vector-table address during stacking and fetch |
| depth_o | output | $clog2(2**PRIO_W+1) | Current nesting depth |

## Verification
The bench builds the block with NUM_IRQ=32, PRIO_W=2, STACK_WORDS=8 and VEC_BASE=0x2000. Four priority levels let the bench nest four handlers deep, reach the depth limit and chain out of it. A nonzero table base makes the address arithmetic visible at the ports. With eight stacking cycles there is room to inject late arrivals both in the middle of stacking and in the last stacking cycle, which pushes the retarget into the fetch cycle. A table of request masks with fixed priorities exercises arbitration ties and disabled lines. Directed sequences then cover tail chaining between equal priorities and the unwinding of the full nest.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int          NUM_IRQ     = 32,
  parameter int          PRIO_W      = 2,
  parameter int          STACK_WORDS = 8,
  parameter int          VEC_OFS     = 16,
  parameter logic [31:0] VEC_BASE    = 32'h0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_IRQ-1:0]                  irq_i,
  input  logic                                cfg_we_i,
  input  logic [$clog2(NUM_IRQ)-1:0]          cfg_idx_i,
  input  logic [PRIO_W:0]                     cfg_data_i,
  output logic                                entry_req_o,
  input  logic                                entry_ack_i,
  input  logic                                exc_ret_i,
  output logic [2:0]                          phase_o,
  output logic [$clog2(VEC_OFS+NUM_IRQ)-1:0]  vec_num_o,
  output logic [31:0]                         vec_addr_o,
  output logic [$clog2((2**PRIO_W)+1)-1:0]    depth_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam int EP_W  = PRIO_W + 1;
  localparam int MAXD  = 2**PRIO_W;
  localparam int DEP_W = $clog2(MAXD + 1);
  localparam int CNT_W = $clog2(STACK_WORDS);
  localparam int VN_W  = $clog2(VEC_OFS + NUM_IRQ);
  localparam logic [EP_W-1:0]  THREAD = EP_W'(MAXD);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(STACK_WORDS - 1);

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_STACK   = 3'd1,
    PH_FETCH   = 3'd2,
    PH_HANDLER = 3'd3,
    PH_UNSTACK = 3'd4
  } phase_t;

  logic [PRIO_W-1:0] prio_q [NUM_IRQ];
  logic [NUM_IRQ-1:0] en_q, pend_q, act_q;
  logic [IDX_W-1:0]   nest_q [MAXD];
  logic [DEP_W-1:0]   depth_q;
  phase_t             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   tgt_q;

  logic [NUM_IRQ-1:0] cand;
  logic               win_any;
  logic [IDX_W-1:0]   win_i;
  logic [EP_W-1:0]    win_p;
  logic [EP_W-1:0]    exec_p, exec_after;
  logic [PRIO_W-1:0]  top_slot;
  logic [IDX_W-1:0]   top_i;
  logic [EP_W-1:0]    tgt_p;
  logic               late_hit, pre_ok, chain_ok, acc, ret;
  logic [IDX_W-1:0]   cur_i;
  logic               show_tgt;

  assign cand     = pend_q & en_q & ~act_q;
  assign top_slot = PRIO_W'(depth_q - 1'b1);
  assign top_i    = (depth_q != '0) ? nest_q[top_slot] : '0;
  assign tgt_p    = {1'b0, prio_q[tgt_q]};

  always_comb begin
    win_any = 1'b0;
    win_i   = '0;
    win_p   = THREAD;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand[i] && ({1'b0, prio_q[i]} <= win_p)) begin
        win_any = 1'b1;
        win_i   = IDX_W'(i);
        win_p   = {1'b0, prio_q[i]};
      end
    end
  end

  always_comb begin
    exec_p     = THREAD;
    exec_after = THREAD;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (act_q[i] && ({1'b0, prio_q[i]} < exec_p))
        exec_p = {1'b0, prio_q[i]};
      if (act_q[i] && (IDX_W'(i) != top_i) && ({1'b0, prio_q[i]} < exec_after))
        exec_after = {1'b0, prio_q[i]};
    end
  end

  assign late_hit = win_any && (win_p < tgt_p);
  assign pre_ok   = win_any && (win_p < exec_p) && (depth_q != DEP_W'(MAXD));
  assign chain_ok = win_any && (win_p < exec_after);
  assign acc      = (ph_q == PH_FETCH) && !late_hit;
  assign ret      = (ph_q == PH_HANDLER) && exc_ret_i;

  assign entry_req_o = ((ph_q == PH_IDLE) || (ph_q == PH_HANDLER)) && pre_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
      en_q <= '0;
    end else if (cfg_we_i) begin
      prio_q[cfg_idx_i] <= cfg_data_i[PRIO_W-1:0];
      en_q[cfg_idx_i]   <= cfg_data_i[PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (acc && (tgt_q == IDX_W'(i)))
          pend_q[i] <= 1'b0;
        else if (irq_i[i] && en_q[i])
          pend_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      depth_q <= '0;
      for (int d = 0; d < MAXD; d++) nest_q[d] <= '0;
    end else if (acc) begin
      act_q[tgt_q]                   <= 1'b1;
      nest_q[depth_q[PRIO_W-1:0]]    <= tgt_q;
      depth_q                        <= depth_q + 1'b1;
    end else if (ret) begin
      act_q[top_i] <= 1'b0;
      depth_q      <= depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tgt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE, PH_HANDLER: begin
          if (ret) begin
            if (chain_ok) begin
              ph_q  <= PH_FETCH;
              tgt_q <= win_i;
            end else begin
              ph_q  <= PH_UNSTACK;
              cnt_q <= '0;
            end
          end else if (entry_req_o && entry_ack_i) begin
            ph_q  <= PH_STACK;
            cnt_q <= '0;
            tgt_q <= win_i;
          end
        end
        PH_STACK: begin
          if (late_hit) tgt_q <= win_i;
          if (cnt_q == LAST) ph_q <= PH_FETCH;
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_FETCH: begin
          if (late_hit) tgt_q <= win_i;
          else ph_q <= PH_HANDLER;
        end
        PH_UNSTACK: begin
          if (cnt_q == LAST) ph_q <= (depth_q == '0) ? PH_IDLE : PH_HANDLER;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign show_tgt   = (ph_q == PH_STACK) || (ph_q == PH_FETCH);
  assign cur_i      = show_tgt ? tgt_q : top_i;
  assign phase_o    = ph_q;
  assign depth_o    = depth_q;
  assign vec_num_o  = ((ph_q == PH_IDLE) || (ph_q == PH_UNSTACK)) ? '0
                      : VN_W'(VEC_OFS) + VN_W'(cur_i);
  assign vec_addr_o = show_tgt ? VEC_BASE + (32'(vec_num_o) << 2) : 32'h0;

  p_stack_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STACK && $past(ph_q) != PH_STACK) |-> $past(entry_req_o && entry_ack_i));

  p_handler_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HANDLER && $past(ph_q) == PH_FETCH) |-> depth_q == DEP_W'($past(depth_q) + 1'b1));

  p_count_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STACK && $past(ph_q) == PH_STACK) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_unstack_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_UNSTACK && $past(ph_q) == PH_UNSTACK) |-> $past(cnt_q) == LAST);

  p_return_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_HANDLER && $past(exc_ret_i)) |-> (ph_q == PH_FETCH || ph_q == PH_UNSTACK));

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(MAXD));

  p_active_matches_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_q) == int'(depth_q));

  p_ret_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_STACK && $past(exc_ret_i)) |-> depth_q == $past(depth_q));
endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [2:0]  cfg_data = '0;
  logic        ack = 1'b0;
  logic        eret = 1'b0;
  logic        req;
  logic [2:0]  phase;
  logic [5:0]  vnum;
  logic [31:0] vaddr;
  logic [2:0]  depth;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_nest_ctrl #(.VEC_BASE(BASE)) u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .entry_req_o(req), .entry_ack_i(ack), .exc_ret_i(eret),
    .phase_o(phase), .vec_num_o(vnum), .vec_addr_o(vaddr), .depth_o(depth)
  );

  // {enable mask, request mask, expected winner (63 = no request)}; priority = 3 - (line % 4)
  localparam logic [71:0] TBL [10] = '{
    {32'hFFFF_FFFF, 32'h0000_0020, 8'd5},
    {32'hFFFF_FFFF, 32'h0000_0003, 8'd1},
    {32'hFFFF_FFFF, 32'h0000_0088, 8'd3},
    {32'hFFFF_FFFF, 32'h8000_0004, 8'd31},
    {32'hFFFF_FFFF, 32'h0000_1110, 8'd4},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd3},
    {32'hFFFF_FFFF, 32'h6000_0000, 8'd30},
    {32'hFFFF_FFF7, 32'h0000_0088, 8'd7},
    {32'h0000_0000, 32'h0000_0200, 8'd63},
    {32'hFFFF_FFFF, 32'h0000_0000, 8'd63}
  };

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; ack = 1'b0; eret = 1'b0; cfg_we = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic cfg(input int idx, input bit en, input int pr);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_data = {en, 2'(pr)};
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic enter(input int line, input int dep, input string rq);
    chk(rq, "entry request", req, 1);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk(rq, "stacking phase", phase, 1);
    repeat (9) tick();
    chk(rq, "handler phase", phase, 3);
    chk(rq, "handler vector", vnum, 16 + line);
    chk(rq, "depth", depth, dep);
  endtask

  task automatic leave_unstack(input int ph_after, input int dep, input int line);
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R7", "unstacking phase", phase, 4);
    repeat (7) tick();
    chk("R7", "still unstacking", phase, 4);
    tick();
    chk("R7", "phase after unstack", phase, ph_after);
    chk("R7", "depth after unstack", depth, dep);
    if (ph_after == 3) chk("R7", "resumed vector", vnum, 16 + line);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1", "reset phase", phase, 0);
    chk("R1", "reset depth", depth, 0);
    chk("R1", "reset request", req, 0);
    chk("R1", "reset vector", vnum, 0);
    chk("R1", "reset address", vaddr, 0);
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R10", "return in idle ignored", phase, 0);

    for (int r = 0; r < 10; r++) begin
      logic [31:0] en_m;
      logic [31:0] rq_m;
      int          ex;
      en_m = TBL[r][71:40];
      rq_m = TBL[r][39:8];
      ex   = int'(TBL[r][7:0]);
      do_reset();
      for (int i = 0; i < 32; i++) cfg(i, en_m[i], 3 - (i % 4));
      irq = rq_m;
      tick();
      if (ex == 63) begin
        chk("R2", "no request from disabled or idle lines", req, 0);
      end else begin
        chk("R3", "request raised", req, 1);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        chk("R3", "stacking phase", phase, 1);
        chk("R3", "winner vector", vnum, 16 + ex);
        chk("R3", "winner address", vaddr, BASE + 32'(4 * (16 + ex)));
      end
      irq = '0;
    end

    // R5 entry timing, R4 equal priority waits, R8 equal-priority tail chain, R7 unstack
    do_reset();
    cfg(10, 1, 2);
    cfg(11, 1, 2);
    irq = 32'h0000_0400;
    tick();
    chk("R5", "request", req, 1);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R5", "stacking first cycle", phase, 1);
    repeat (7) tick();
    chk("R5", "stacking last cycle", phase, 1);
    tick();
    chk("R5", "fetch cycle", phase, 2);
    tick();
    chk("R5", "handler", phase, 3);
    chk("R5", "depth", depth, 1);
    chk("R5", "vector", vnum, 26);
    irq = 32'h0000_0800;
    tick();
    chk("R4", "equal priority no preemption", req, 0);
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R8", "chain goes to fetch", phase, 2);
    chk("R8", "chain target", vnum, 27);
    tick();
    chk("R8", "chained handler", phase, 3);
    chk("R8", "chained depth", depth, 1);
    irq = '0;
    leave_unstack(0, 0, 0);

    // R6 late arrival mid stacking, R10 return ignored, R11 displaced stays pending
    do_reset();
    cfg(5, 1, 2);
    cfg(6, 1, 0);
    irq = 32'h0000_0020;
    tick();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R6", "initial target", vnum, 21);
    tick();
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R10", "return during stacking ignored", phase, 1);
    irq = 32'h0000_0060;
    tick();
    tick();
    chk("R6", "retargeted vector", vnum, 22);
    chk("R6", "still stacking", phase, 1);
    repeat (3) tick();
    chk("R6", "count not restarted", phase, 1);
    tick();
    chk("R6", "fetch on time", phase, 2);
    tick();
    chk("R6", "handler of late line", vnum, 22);
    chk("R10", "depth unchanged by ignored return", depth, 1);
    irq = '0;
    tick();
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R11", "displaced line chained", phase, 2);
    chk("R11", "displaced vector", vnum, 21);
    tick();
    chk("R11", "displaced handler", phase, 3);
    leave_unstack(0, 0, 0);

    // R6 late arrival in the last stacking cycle lands in fetch
    do_reset();
    cfg(7, 1, 3);
    cfg(8, 1, 1);
    irq = 32'h0000_0080;
    tick();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    repeat (7) tick();
    irq = 32'h0000_0180;
    tick();
    chk("R6", "fetch with old target", vnum, 23);
    chk("R6", "fetch phase", phase, 2);
    tick();
    chk("R6", "fetch repeated", phase, 2);
    chk("R6", "fetch retargeted", vnum, 24);
    tick();
    chk("R6", "handler after repeat", phase, 3);
    chk("R6", "handler vector", vnum, 24);
    irq = '0;
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R8", "chain to thread-level wait", phase, 2);
    tick();
    chk("R8", "chained vector", vnum, 23);
    leave_unstack(0, 0, 0);

    // R9 nesting four deep, depth cap, chain at full depth, unwinding
    do_reset();
    cfg(20, 1, 3);
    cfg(21, 1, 2);
    cfg(22, 1, 1);
    cfg(23, 1, 0);
    cfg(25, 1, 0);
    for (int k = 0; k < 4; k++) begin
      irq = 32'h1 << (20 + k);
      tick();
      enter(20 + k, k + 1, "R9");
    end
    irq = '0;
    cfg(23, 1, 3);
    irq = 32'h0200_0000;
    tick();
    chk("R9", "no entry at max depth", req, 0);
    eret = 1'b1;
    tick();
    eret = 1'b0;
    chk("R8", "chain from full depth", phase, 2);
    tick();
    chk("R8", "chained handler", vnum, 41);
    chk("R9", "depth kept by chain", depth, 4);
    irq = '0;
    leave_unstack(3, 3, 22);
    leave_unstack(3, 2, 21);
    leave_unstack(3, 1, 20);
    leave_unstack(0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule